// File: doc/BRIEF.md
# Iterative Integer Multiplier with Per-Operand Signedness

This block computes the product of two XLEN-bit integer operands for an integer execution pipeline. Each operand carries its own signedness flag, so one unit covers signed by signed, signed by unsigned, unsigned by signed and unsigned by unsigned products. A half-select input chooses whether the lower or the upper XLEN bits of the 2*XLEN-bit product are returned. The datapath is a radix-4 Booth recoder feeding a single accumulator. It retires two multiplier bits per clock.

A request is taken through a valid/ready pair only while the unit is idle. The result appears after a fixed number of cycles and stays on the response port until the consumer takes it. The latency does not depend on the operand values, so the unit is safe for code that must not leak data through timing. An enable input reflects whether the multiply extension is switched on. A request accepted while it is low comes back as an illegal-instruction response with no result data, after the same latency.

Top module: `imul_unit`

## Requirements
- R1: With want_high=0 the response carries bits XLEN-1..0 of the full product, and bits above them are discarded. This holds for every setting of the signedness flags.
- R2: With want_high=1, a_signed=1 and b_signed=1, the response carries bits 2*XLEN-1..XLEN of the product of both operands read as two's complement.
- R3: With want_high=1 and exactly one signedness flag set, the flagged operand is read as two's complement and the other as unsigned. The signed-first case is a_signed=1, b_signed=0. The response is the upper half of that product.
- R4: With want_high=1, a_signed=0 and b_signed=0, the response is the upper half of the unsigned product.
- R5: In the signed by signed upper-half case, the most negative value times -1 yields the correct upper half, 0 for a product of 2^(XLEN-1). The most negative value times itself yields 2^(XLEN-2).
- R6: rsp_valid rises exactly XLEN/2+2 rising clock edges after the edge that accepts a request. This holds for every operand value, including zero, one and negative values.
- R7: req_ready is 1 only when the unit is idle. A request presented while busy is not accepted, and it produces no response.
- R8: While rsp_valid=1 and rsp_ready=0, rsp_valid, rsp_result and rsp_illegal stay unchanged.
- R9: A request accepted with ext_enable=0 returns rsp_illegal=1 and rsp_result=0 after the same latency. One accepted with ext_enable=1 returns rsp_illegal=0.
- R10: A synchronous active-high reset, even one that arrives mid-operation, returns the unit to idle with req_ready=1 and rsp_valid=0. The pending operation produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle and able to take a request |
| op_a | input | XLEN | First operand (multiplicand) |
| op_b | input | XLEN | Second operand (multiplier) |
| a_signed | input | 1 | 1: op_a is two's complement |
| b_signed | input | 1 | 1: op_b is two's complement |
| want_high | input | 1 | 1: return upper half, 0: lower half |
| ext_enable | input | 1 | Multiply extension enabled; 0 gives an illegal response |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_result | output | XLEN | Selected half of the product, 0 when illegal |
| rsp_illegal | output | 1 | Illegal-instruction indication |

## Verification
Two conditions are the hardest to reach from the ports. The first is a reset that lands while an operation is in flight. The second is a request held valid during the busy window. The stimulus produces both directly: it accepts an operation, raises reset a few cycles later, and then confirms that the unit is idle and that no stray response appears. It also drives junk requests during the busy window and confirms that only the original result returns. The sign corners come from directed operands: the most negative value, -1, zero and one, under every pairing of the signedness flags. A seeded random mix follows, with the response side stalled so that held results are exercised.

// File: rtl/imul_pkg.sv
package imul_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2,
    ST_HOLD = 2'd3
  } imul_state_e;

  // Booth radix-4 digit controls
  typedef struct packed {
    logic zero;
    logic dbl;
    logic neg;
  } booth_dig_t;

  function automatic booth_dig_t booth_decode(input logic [2:0] trip);
    booth_dig_t d;
    d.zero = (trip == 3'b000) || (trip == 3'b111);
    d.dbl  = (trip == 3'b011) || (trip == 3'b100);
    d.neg  = trip[2] && !d.zero;
    return d;
  endfunction

endpackage

// File: rtl/imul_booth_pp.sv
module imul_booth_pp #(
  parameter int PW = 64
) (
  input  logic [2:0]    trip,
  input  logic [PW-1:0] mcand,
  output logic [PW-1:0] pp
);
  import imul_pkg::*;

  booth_dig_t        dig;
  logic [PW-1:0]     mag;

  always_comb begin
    dig = booth_decode(trip);
    if (dig.zero)      mag = '0;
    else if (dig.dbl)  mag = {mcand[PW-2:0], 1'b0};
    else               mag = mcand;
    pp = dig.neg ? (~mag + PW'(1)) : mag;
  end

endmodule

// File: rtl/imul_ctrl.sv
module imul_ctrl #(
  parameter int STEPS = 17
) (
  input  logic clk,
  input  logic rst,
  input  logic req_valid,
  input  logic rsp_ready,
  output logic req_ready,
  output logic rsp_valid,
  output logic load,
  output logic step,
  output logic finish
);
  import imul_pkg::*;

  localparam int CW = $clog2(STEPS + 1);

  imul_state_e   state;
  logic [CW-1:0] cnt;

  assign req_ready = (state == ST_IDLE);
  assign load      = req_ready && req_valid;
  assign step      = (state == ST_RUN);
  assign finish    = (state == ST_FIN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      rsp_valid <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (req_valid) begin
          state <= ST_RUN;
          cnt   <= '0;
        end
        ST_RUN: begin
          cnt <= cnt + CW'(1);
          if (cnt == CW'(STEPS - 1)) state <= ST_FIN;
        end
        ST_FIN: begin
          state     <= ST_HOLD;
          rsp_valid <= 1'b1;
        end
        ST_HOLD: if (rsp_ready) begin
          state     <= ST_IDLE;
          rsp_valid <= 1'b0;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready); // R7

  AST_NO_READY_WITH_RSP: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !req_ready); // R7

endmodule

// File: rtl/imul_datapath.sv
module imul_datapath #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic            step,
  input  logic            finish,
  input  logic [XLEN-1:0] op_a,
  input  logic [XLEN-1:0] op_b,
  input  logic            a_signed,
  input  logic            b_signed,
  input  logic            want_high,
  input  logic            ext_enable,
  output logic [XLEN-1:0] result,
  output logic            illegal
);

  localparam int PW = 2 * XLEN;   // product width kept
  localparam int MW = XLEN + 2;   // extended multiplier, even width

  logic [PW-1:0] mcand;
  logic [MW-1:0] mplier;
  logic          prev;
  logic [PW-1:0] acc;
  logic          hi_q;
  logic          legal_q;
  logic [PW-1:0] pp;
  logic [XLEN-1:0] half_sel;

  imul_booth_pp #(.PW(PW)) u_pp (
    .trip  ({mplier[1:0], prev}),
    .mcand (mcand),
    .pp    (pp)
  );

  generate
    if (XLEN > 1) begin : g_half
      assign half_sel = hi_q ? acc[PW-1:XLEN] : acc[XLEN-1:0];
    end else begin : g_half_min
      assign half_sel = hi_q ? acc[1] : acc[0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (load) begin
      mcand   <= {{XLEN{a_signed & op_a[XLEN-1]}}, op_a};
      mplier  <= {{2{b_signed & op_b[XLEN-1]}}, op_b};
      prev    <= 1'b0;
      acc     <= '0;
      hi_q    <= want_high;
      legal_q <= ext_enable;
    end else if (step) begin
      acc    <= acc + pp;
      mcand  <= {mcand[PW-3:0], 2'b00};
      prev   <= mplier[1];
      mplier <= {{2{mplier[MW-1]}}, mplier[MW-1:2]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result  <= '0;
      illegal <= 1'b0;
    end else if (finish) begin
      result  <= legal_q ? half_sel : '0;
      illegal <= !legal_q;
    end
  end

  AST_ONE_CONTROL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({load, step, finish})); // R6

endmodule

// File: rtl/imul_unit.sv
module imul_unit #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [XLEN-1:0] op_a,
  input  logic [XLEN-1:0] op_b,
  input  logic            a_signed,
  input  logic            b_signed,
  input  logic            want_high,
  input  logic            ext_enable,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic [XLEN-1:0] rsp_result,
  output logic            rsp_illegal
);

  localparam int STEPS = (XLEN + 2) / 2;
  localparam int LAT   = STEPS + 1;
  localparam int OW    = $clog2(LAT + 1);

  logic load, step, finish;

  imul_ctrl #(.STEPS(STEPS)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .rsp_ready (rsp_ready),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .load      (load),
    .step      (step),
    .finish    (finish)
  );

  imul_datapath #(.XLEN(XLEN)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .load       (load),
    .step       (step),
    .finish     (finish),
    .op_a       (op_a),
    .op_b       (op_b),
    .a_signed   (a_signed),
    .b_signed   (b_signed),
    .want_high  (want_high),
    .ext_enable (ext_enable),
    .result     (rsp_result),
    .illegal    (rsp_illegal)
  );

  // observation counter for the fixed-latency check
  logic [OW-1:0] obs_cnt;
  always_ff @(posedge clk) begin
    if (rst)                         obs_cnt <= '0;
    else if (req_valid && req_ready) obs_cnt <= OW'(1);
    else if (obs_cnt != '0 && obs_cnt < OW'(LAT)) obs_cnt <= obs_cnt + OW'(1);
  end

  AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (rst)
    $rose(rsp_valid) |-> (obs_cnt == OW'(LAT))); // R6

  AST_HOLD_RESPONSE: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_result) && $stable(rsp_illegal))); // R8

  AST_ILLEGAL_NO_DATA: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_illegal) |-> (rsp_result == '0)); // R9

  AST_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (req_ready && !rsp_valid)); // R10

endmodule

// File: tb/imul_unit_tb.sv
module imul_unit_tb;

  localparam int XLEN = 32;
  localparam int LAT  = XLEN / 2 + 2;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            req_valid = 1'b0;
  logic            req_ready;
  logic [XLEN-1:0] op_a = '0;
  logic [XLEN-1:0] op_b = '0;
  logic            a_signed = 1'b0;
  logic            b_signed = 1'b0;
  logic            want_high = 1'b0;
  logic            ext_enable = 1'b1;
  logic            rsp_valid;
  logic            rsp_ready = 1'b1;
  logic [XLEN-1:0] rsp_result;
  logic            rsp_illegal;

  int     checks = 0;
  int     failures = 0;
  longint cyc = 0;
  bit     stall_mode = 1'b0;
  bit     in_resp = 1'b0;
  logic [XLEN-1:0] held_res;
  logic            held_ill;

  typedef struct {
    logic [XLEN-1:0] res;
    logic            ill;
    longint          acc_cyc;
    string           req;
  } exp_t;
  exp_t exp_q[$];

  imul_unit #(.XLEN(XLEN)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .op_a(op_a), .op_b(op_b), .a_signed(a_signed), .b_signed(b_signed),
    .want_high(want_high), .ext_enable(ext_enable), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_result(rsp_result), .rsp_illegal(rsp_illegal)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [XLEN-1:0] model(input logic [XLEN-1:0] a, input logic [XLEN-1:0] b,
                                            input bit as, input bit bs, input bit hi);
    longint av, bv;
    logic [63:0] p;
    av = as ? longint'($signed(a)) : longint'(a);
    bv = bs ? longint'($signed(b)) : longint'(b);
    p  = av * bv;
    return hi ? p[63:32] : p[31:0];
  endfunction

  task automatic send(input logic [XLEN-1:0] a, input logic [XLEN-1:0] b, input bit as,
                      input bit bs, input bit hi, input bit en, input string req);
    exp_t e;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; op_a = a; op_b = b; a_signed = as; b_signed = bs;
    want_high = hi; ext_enable = en;
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    e.res = en ? model(a, b, as, bs, hi) : '0;
    e.ill = !en;
    e.acc_cyc = cyc;
    e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic drain();
    while (exp_q.size() != 0 || rsp_valid) @(negedge clk);
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst) begin
      in_resp = 1'b0;
    end else if (rsp_valid) begin
      if (!in_resp) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R7", "response without accepted request", 64'(rsp_result), 64'hx);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(rsp_result == e.res, e.req, "result", 64'(rsp_result), 64'(e.res));
          check(rsp_illegal == e.ill, "R9", "illegal flag", 64'(rsp_illegal), 64'(e.ill));
          check(cyc - e.acc_cyc == LAT, "R6", "latency", 64'(cyc - e.acc_cyc), 64'(LAT));
        end
        held_res = rsp_result;
        held_ill = rsp_illegal;
        in_resp  = 1'b1;
      end else begin
        check(rsp_result == held_res && rsp_illegal == held_ill, "R8", "held response",
              64'(rsp_result), 64'(held_res));
      end
      rsp_ready = stall_mode ? (cyc % 3 == 0) : 1'b1;
      if (rsp_ready) in_resp = 1'b0;
    end
  end

  localparam logic [XLEN-1:0] MOSTNEG = {1'b1, {(XLEN-1){1'b0}}};
  localparam logic [XLEN-1:0] ALL1    = '1;

  initial begin
    repeat (3) @(negedge clk);
    check(req_ready == 1'b1, "R10", "req_ready in reset", 64'(req_ready), 64'd1);
    check(rsp_valid == 1'b0, "R10", "rsp_valid in reset", 64'(rsp_valid), 64'd0);
    rst = 1'b0;

    // R1 low half, all signedness settings, overflow discarded
    send(32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, 0, 1, "R1");
    send(32'h1234_5678, 32'h9ABC_DEF0, 1, 1, 0, 1, "R1");
    send(32'h8000_0001, 32'h0000_0003, 1, 0, 0, 1, "R1");
    send(32'h0000_0000, 32'hDEAD_BEEF, 0, 1, 0, 1, "R1");
    // R2 signed x signed high
    send(32'hFFFF_FFFE, 32'h0000_0003, 1, 1, 1, 1, "R2");
    send(32'h7FFF_FFFF, 32'h7FFF_FFFF, 1, 1, 1, 1, "R2");
    send(32'h0000_0001, 32'hFFFF_FFFF, 1, 1, 1, 1, "R2");
    // R3 mixed signedness high
    send(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, 0, 1, 1, "R3");
    send(32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 1, 1, 1, "R3");
    send(MOSTNEG, 32'h0000_0002, 1, 0, 1, 1, "R3");
    // R4 unsigned high
    send(32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, 1, 1, "R4");
    send(32'h8000_0000, 32'h0000_0002, 0, 0, 1, 1, "R4");
    // R5 corners
    send(MOSTNEG, ALL1, 1, 1, 1, 1, "R5");
    send(MOSTNEG, MOSTNEG, 1, 1, 1, 1, "R5");
    send(ALL1, MOSTNEG, 1, 1, 1, 1, "R5");
    // R9 disabled extension
    send(32'h0000_0007, 32'h0000_0009, 1, 1, 0, 0, "R9");
    send(32'h0000_0007, 32'h0000_0009, 1, 1, 0, 1, "R9");
    drain();

    // R7 requests while busy are refused
    send(32'h0000_0011, 32'h0000_0022, 0, 0, 0, 1, "R7");
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      req_valid = 1'b1; op_a = 32'hBAD0_0000 + 32'(i); op_b = 32'h5; ext_enable = 1'b1;
      check(req_ready == 1'b0, "R7", "req_ready while busy", 64'(req_ready), 64'd0);
    end
    @(negedge clk);
    req_valid = 1'b0;
    drain();
    for (int i = 0; i < LAT + 4; i++) begin
      @(negedge clk);
      check(rsp_valid == 1'b0, "R7", "no response for refused request", 64'(rsp_valid), 64'd0);
    end

    // R8 stalled consumer with random mix
    stall_mode = 1'b1;
    for (int i = 0; i < 60; i++) begin
      logic [XLEN-1:0] a, b;
      bit as, bs, hi;
      string tag;
      a = $urandom; b = $urandom;
      if (i % 7 == 0) a = MOSTNEG;
      if (i % 5 == 0) b = ALL1;
      as = $urandom_range(0, 1); bs = $urandom_range(0, 1); hi = $urandom_range(0, 1);
      if (!hi) tag = "R1";
      else if (as && bs) tag = "R2";
      else if (as || bs) tag = "R3";
      else tag = "R4";
      send(a, b, as, bs, hi, 1, tag);
    end
    drain();
    stall_mode = 1'b0;
    @(negedge clk);
    rsp_ready = 1'b1;

    // R10 reset mid-operation
    send(32'h0000_0005, 32'h0000_0006, 0, 0, 0, 1, "R10");
    repeat (4) @(negedge clk);
    rst = 1'b1;
    exp_q.delete();
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(req_ready == 1'b1, "R10", "idle after reset", 64'(req_ready), 64'd1);
    check(rsp_valid == 1'b0, "R10", "no valid after reset", 64'(rsp_valid), 64'd0);
    for (int i = 0; i < LAT + 4; i++) begin
      @(negedge clk);
      check(rsp_valid == 1'b0, "R10", "aborted op silent", 64'(rsp_valid), 64'd0);
    end
    send(32'h0000_0005, 32'h0000_0006, 0, 0, 0, 1, "R10");
    drain();

    report();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    report();
    $finish;
  end

endmodule